// File: doc/BRIEF.md
# Root Hub Status and Control Register

This block is one 32-bit register of a USB host controller's root hub. It sits on a simple register bus: address, write strobe and write data in, combinational read data out. Most of its bit positions do one thing when read and another when written. A write of 1 sets, clears or switches something. A read returns a status bit, or a constant 0 where the feature is absent. Writing 0 to any action bit does nothing.

The register holds the device remote wakeup enable. It samples a global overcurrent input through a two-flop synchronizer and raises a sticky change flag when the reported overcurrent level flips. It also switches power on or off for a parameterised set of downstream ports. A power-switching-mode input and a per-port mask decide which ports a power write reaches. The block combines the wakeup enable with a connect-status-change pulse to produce a resume-event output, which a separate suspend/resume controller consumes.

Top module: `roothub_stat_ctl`

## Requirements
- R1: After reset the read data is 0 at every position, every `port_pwr` bit is 0 and `resume_evt` is 0.
- R2: A write with data bit 15 at 1 sets the wakeup enable. Bit 15 reads the enable back. A write with bit 15 at 0 leaves the enable unchanged.
- R3: A write with data bit 31 at 1 clears the wakeup enable. When bits 31 and 15 are both 1 in one write, the enable ends at 0. Bit 31 always reads 0.
- R4: `resume_evt` is 1 in exactly the cycles where `conn_chg` is 1 and the wakeup enable is 1.
- R5: Read bit 1 shows `ovc_in` after a two-flop synchronizer (1 = overcurrent). It reads 0 whenever `per_port_ovc` is 1.
- R6: Read bit 17 is set on the clock edge after read bit 1 changes value. A write with bit 17 at 1 clears it. A write with bit 17 at 0 leaves it unchanged.
- R7: If a bit-1 change and a write-1 to bit 17 fall in the same cycle, bit 17 ends at 1.
- R8: With `pwr_sw_mode` at 0 (global), a write with bit 16 at 1 turns on every port.
- R9: With `pwr_sw_mode` at 1 (per-port), power writes reach only ports whose `pwr_mask` bit is 0. Masked ports keep their state.
- R10: A write with bit 0 at 1 turns off the selected ports. If bits 16 and 0 are both 1, the selected ports end off.
- R11: Bits 16 and 0 always read 0. Reserved bits 30:18 and 14:2 read 0, and writing 1s to them changes no state.
- R12: Writes to an address other than `REG_ADDR` change no state. Reads from another address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when the address matches |
| ovc_in | input | 1 | Global overcurrent level, asynchronous |
| per_port_ovc | input | 1 | 1 when overcurrent is reported per port, which forces bit 1 to 0 |
| pwr_sw_mode | input | 1 | 0 = global power switching, 1 = per-port |
| pwr_mask | input | NUM_PORTS | Per-port mask; 1 shields that port from power writes in per-port mode |
| conn_chg | input | 1 | Connect status change pulse |
| port_pwr | output | NUM_PORTS | Power state per port |
| resume_evt | output | 1 | Connect change qualified as a resume event |

## Verification
Two events can land on the same clock edge: a hardware change of the synchronized overcurrent level and a software write-1 to clear the change flag. The bench provokes this by counting edges from the moment it toggles `ovc_in`. It places the clearing write on the exact edge where the synchronized level differs from its previous value, and expects the flag to stay 1. A clear on a quiet edge, made afterwards, must drop the flag. The same style of collision is tested on the control side: a clear and a set of the wakeup enable in one write, and an on and an off power command in one write.

// File: rtl/rhs_pkg.sv
package rhs_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned B_WAKE_CLR = 31;
  localparam int unsigned B_OVC_CHG  = 17;
  localparam int unsigned B_PWR_ON   = 16;
  localparam int unsigned B_WAKE     = 15;
  localparam int unsigned B_OVC      = 1;
  localparam int unsigned B_PWR_OFF  = 0;

  typedef struct packed {
    logic wake_clr;
    logic wake_set;
    logic chg_clr;
    logic pwr_on;
    logic pwr_off;
  } rhs_cmd_t;
endpackage

// File: rtl/rhs_rst_sync.sv
module rhs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rhs_wake_ctl.sv
module rhs_wake_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_set,
  input  logic wake_clr,
  input  logic conn_chg,
  output logic wake_en,
  output logic resume_evt
);
  logic wake_q, wake_d;

  always_comb begin
    wake_d = wake_q;
    if (wake_clr)      wake_d = 1'b0;
    else if (wake_set) wake_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  assign wake_en    = wake_q;
  assign resume_evt = conn_chg & wake_q;

  assert_clr_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_clr |=> !wake_en);
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_set && !wake_clr) |=> wake_en);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_set && !wake_clr) |=> $stable(wake_en));
endmodule

// File: rtl/rhs_ovc_track.sv
module rhs_ovc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ovc_async,
  input  logic per_port_ovc,
  input  logic flag_clr,
  output logic oci,
  output logic chg_flag
);
  logic s1_q, s2_q, prev_q, flag_q;
  logic chg, flag_d;

  always_comb begin
    oci    = ~per_port_ovc & s2_q;
    chg    = oci ^ prev_q;
    flag_d = flag_q;
    if (chg)           flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      s1_q   <= ovc_async;
      s2_q   <= s1_q;
      prev_q <= oci;
      flag_q <= flag_d;
    end
  end

  assign chg_flag = flag_q;

  assert_hw_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && flag_clr) |=> chg_flag);
  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !chg) |=> !chg_flag);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && !flag_clr) |=> $stable(chg_flag));
endmodule

// File: rtl/rhs_port_pwr.sv
module rhs_port_pwr #(
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_on,
  input  logic                 pwr_off,
  input  logic                 per_port_mode,
  input  logic [NUM_PORTS-1:0] mask,
  output logic [NUM_PORTS-1:0] pwr
);
  logic [NUM_PORTS-1:0] pwr_q, pwr_d, sel;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    always_comb begin
      sel[i]   = ~per_port_mode | ~mask[i];
      pwr_d[i] = pwr_q[i];
      if (sel[i] && pwr_off)     pwr_d[i] = 1'b0;
      else if (sel[i] && pwr_on) pwr_d[i] = 1'b1;
    end

    assert_masked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (per_port_mode && mask[i]) |=> $stable(pwr[i]));
    assert_off_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_off && (!per_port_mode || !mask[i])) |=> !pwr[i]);
    assert_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && !pwr_off && !per_port_mode) |=> pwr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= '0;
    else        pwr_q <= pwr_d;
  end

  assign pwr = pwr_q;
endmodule

// File: rtl/roothub_stat_ctl.sv
module roothub_stat_ctl
  import rhs_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 ovc_in,
  input  logic                 per_port_ovc,
  input  logic                 pwr_sw_mode,
  input  logic [NUM_PORTS-1:0] pwr_mask,
  input  logic                 conn_chg,
  output logic [NUM_PORTS-1:0] port_pwr,
  output logic                 resume_evt
);
  localparam logic [DATA_W-1:0] RSVD_MASK =
    ~((DATA_W'(1) << B_WAKE_CLR) | (DATA_W'(1) << B_OVC_CHG) |
      (DATA_W'(1) << B_PWR_ON)   | (DATA_W'(1) << B_WAKE)    |
      (DATA_W'(1) << B_OVC)      | (DATA_W'(1) << B_PWR_OFF));

  logic     rst_sync_n;
  logic     hit;
  rhs_cmd_t cmd;
  logic     wake_en, oci, chg_flag;
  logic     unused_rsvd_wdata;

  rhs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    hit          = (bus_addr == REG_ADDR);
    cmd.wake_clr = hit & bus_wr & bus_wdata[B_WAKE_CLR];
    cmd.wake_set = hit & bus_wr & bus_wdata[B_WAKE];
    cmd.chg_clr  = hit & bus_wr & bus_wdata[B_OVC_CHG];
    cmd.pwr_on   = hit & bus_wr & bus_wdata[B_PWR_ON];
    cmd.pwr_off  = hit & bus_wr & bus_wdata[B_PWR_OFF];
  end

  assign unused_rsvd_wdata = ^(bus_wdata & RSVD_MASK);

  rhs_wake_ctl u_wake (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wake_set   (cmd.wake_set),
    .wake_clr   (cmd.wake_clr),
    .conn_chg   (conn_chg),
    .wake_en    (wake_en),
    .resume_evt (resume_evt)
  );

  rhs_ovc_track u_ovc (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ovc_async    (ovc_in),
    .per_port_ovc (per_port_ovc),
    .flag_clr     (cmd.chg_clr),
    .oci          (oci),
    .chg_flag     (chg_flag)
  );

  rhs_port_pwr #(.NUM_PORTS(NUM_PORTS)) u_pwr (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .pwr_on        (cmd.pwr_on),
    .pwr_off       (cmd.pwr_off),
    .per_port_mode (pwr_sw_mode),
    .mask          (pwr_mask),
    .pwr           (port_pwr)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[B_OVC_CHG] = chg_flag;
      bus_rdata[B_WAKE]    = wake_en;
      bus_rdata[B_OVC]     = oci;
    end
  end

  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rdata & (RSVD_MASK | (DATA_W'(1) << B_WAKE_CLR) | (DATA_W'(1) << B_PWR_ON)
      | (DATA_W'(1) << B_PWR_OFF))) == '0);
  assert_oci_masked_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    per_port_ovc |-> !bus_rdata[B_OVC]);
  assert_resume_qual_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    resume_evt |-> (conn_chg && wake_en));
  assert_miss_quiet_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |=> ($stable(wake_en) && $stable(port_pwr)));
endmodule

// File: tb/roothub_stat_ctl_tb.sv
module roothub_stat_ctl_tb;
  localparam int NP = 2;
  localparam logic [7:0] RA = 8'h50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = RA;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          ovc_in = 1'b0;
  logic          per_port_ovc = 1'b0;
  logic          pwr_sw_mode = 1'b0;
  logic [NP-1:0] pwr_mask = '0;
  logic          conn_chg = 1'b0;
  logic [NP-1:0] port_pwr;
  logic          resume_evt;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  roothub_stat_ctl #(.NUM_PORTS(NP), .ADDR_W(8), .REG_ADDR(RA)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovc_in(ovc_in),
    .per_port_ovc(per_port_ovc), .pwr_sw_mode(pwr_sw_mode),
    .pwr_mask(pwr_mask), .conn_chg(conn_chg), .port_pwr(port_pwr),
    .resume_evt(resume_evt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; bus_addr = RA;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 port_pwr", {30'h0, port_pwr}, 32'h0);
    chk("R1 resume", {31'h0, resume_evt}, 32'h0);
  endtask

  task automatic t_wake;
    wr(RA, 32'h0000_8000);
    chk("R2 set", bus_rdata, 32'h0000_8000);
    wr(RA, 32'h0);
    chk("R2 write0 holds", bus_rdata, 32'h0000_8000);
    conn_chg = 1'b1; #1;
    chk("R4 resume enabled", {31'h0, resume_evt}, 32'h1);
    conn_chg = 1'b0; #1;
    chk("R4 no pulse", {31'h0, resume_evt}, 32'h0);
    wr(RA, 32'h8000_0000);
    chk("R3 clear", bus_rdata, 32'h0);
    conn_chg = 1'b1; #1;
    chk("R4 resume disabled", {31'h0, resume_evt}, 32'h0);
    conn_chg = 1'b0;
    wr(RA, 32'h0000_8000);
    wr(RA, 32'h8000_8000);
    chk("R3 clear beats set", bus_rdata, 32'h0);
  endtask

  task automatic t_ovc;
    ovc_in = 1'b1;
    idle(4);
    chk("R5 oci read", bus_rdata & 32'h2, 32'h2);
    chk("R6 flag set", bus_rdata & 32'h2_0000, 32'h2_0000);
    wr(RA, 32'h0);
    chk("R6 write0 keeps", bus_rdata & 32'h2_0000, 32'h2_0000);
    wr(RA, 32'h2_0000);
    chk("R6 w1c", bus_rdata, 32'h2);
    per_port_ovc = 1'b1; #1;
    chk("R5 per-port forces 0", bus_rdata & 32'h2, 32'h0);
    idle(2);
    wr(RA, 32'h2_0000);
    chk("R6 cleared again", bus_rdata, 32'h0);
    per_port_ovc = 1'b0;
    idle(2);
    wr(RA, 32'h2_0000);
    chk("R5 level back", bus_rdata, 32'h2);
  endtask

  task automatic t_race;
    // ovc_in is 1 and flag clear; force a change with the flag already set
    @(negedge clk);
    wr(RA, 32'h0);
    ovc_in = 1'b0;
    idle(4);
    chk("R6 fall sets flag", bus_rdata, 32'h2_0000);
    ovc_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = RA; bus_wdata = 32'h2_0000; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    chk("R7 hw set wins", bus_rdata & 32'h2_0000, 32'h2_0000);
    wr(RA, 32'h2_0000);
    chk("R7 later clear", bus_rdata & 32'h2_0000, 32'h0);
  endtask

  task automatic t_power;
    pwr_sw_mode = 1'b0;
    wr(RA, 32'h1_0000);
    chk("R8 global on", {30'h0, port_pwr}, 32'h3);
    chk("R11 pwr bits read 0", bus_rdata & 32'h1_0001, 32'h0);
    wr(RA, 32'h1);
    chk("R10 global off", {30'h0, port_pwr}, 32'h0);
    pwr_sw_mode = 1'b1; pwr_mask = 2'b01;
    wr(RA, 32'h1_0000);
    chk("R9 masked on", {30'h0, port_pwr}, 32'h2);
    pwr_sw_mode = 1'b0;
    wr(RA, 32'h1_0000);
    pwr_sw_mode = 1'b1; pwr_mask = 2'b10;
    wr(RA, 32'h1);
    chk("R9 masked off", {30'h0, port_pwr}, 32'h2);
    pwr_sw_mode = 1'b0;
    wr(RA, 32'h1_0001);
    chk("R10 off beats on", {30'h0, port_pwr}, 32'h0);
  endtask

  task automatic t_ignore;
    wr(8'h54, 32'h0001_8000);
    chk("R12 other addr wake", bus_rdata & 32'h8000, 32'h0);
    chk("R12 other addr pwr", {30'h0, port_pwr}, 32'h0);
    bus_addr = 8'h54; #1;
    chk("R12 other addr reads 0", bus_rdata, 32'h0);
    bus_addr = RA;
    wr(RA, 32'h7FFC_7FFC);
    chk("R11 reserved ignored", bus_rdata, 32'h2);
    chk("R11 reserved pwr", {30'h0, port_pwr}, 32'h0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset;
    t_wake;
    t_ovc;
    t_race;
    t_power;
    t_ignore;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule